// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation cache on a miss, with no software involved. It takes the virtual page number that missed and walks a two-level page table. The tables sit in memory at a base address given by a register, and every entry has the same fixed layout. The walker uses the upper part of the page number to select an entry in the top table. That entry either names the frame that holds a second-level table or reports the table as absent. If the table is present, the walker reads the leaf entry from it. The result is a one-cycle refill pulse that carries the page number, the frame number and the flag bits, or a one-cycle fault pulse that says at which level the walk stopped.

A sparse address space leaves whole second-level tables unallocated. The walker therefore ends the walk as soon as a top entry reports its table as absent and makes no second memory read. It handles one miss at a time and shows this on `busy`. All memory traffic goes through a single read port: a request channel with a valid/ready handshake and a response channel with a valid flag only.

Top module: `ptw_walker`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `busy`, `mem_req_valid`, `refill_valid` and `fault_valid` are low.
- R2: A miss is accepted on a clock edge where `miss_valid` is high and `busy` is low. `busy` is high from the next cycle through the cycle of the result pulse, and low in the cycle after that pulse.
- R3: A miss presented while `busy` is high is ignored. The reported page number stays the one accepted, and no extra memory read is made.
- R4: The first read of a walk goes to `pt_base + 4 * miss_vpn[19:10]`.
- R5: A table entry is 32 bits wide. Bit 0 means valid/present, bit 1 writable, bit 2 referenced, bit 3 dirty. Bits 31:12 hold the frame number.
- R6: The second read goes to `top_frame * 4096 + 4 * miss_vpn[9:0]`, where `top_frame` is bits 31:12 of the top entry.
- R7: If the top entry has bit 0 clear, the walk ends with `fault_valid` and `fault_level = 0` after exactly one memory read.
- R8: If the leaf entry has bit 0 clear, the walk ends with `fault_valid` and `fault_level = 1` after two memory reads.
- R9: A successful walk raises `refill_valid` for one cycle. At the same time `refill_vpn` carries the accepted page number, `refill_frame` carries leaf bits 31:12 and `refill_flags` carries leaf bits 3:0 (dirty, referenced, writable, valid).
- R10: A request held back by a low `mem_req_ready` keeps its valid and address unchanged until accepted. A stalled walk still gives the correct result.
- R11: With a memory that is always ready and answers one cycle after the handshake, the result pulse appears 4 edges after the accept edge, or 2 edges after it for a top-level fault.
- R12: Each accepted miss produces exactly one result pulse, which is either a refill or a fault, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_base | input | 32 | Byte address of the top-level table; hold stable during a walk |
| miss_valid | input | 1 | Miss request present |
| miss_vpn | input | 20 | Virtual page number that missed |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data (one table entry) |
| refill_valid | output | 1 | One-cycle refill pulse |
| refill_vpn | output | 20 | Page number of the refill |
| refill_frame | output | 20 | Frame number from the leaf entry |
| refill_flags | output | 4 | Leaf flags {dirty, referenced, writable, valid} |
| fault_valid | output | 1 | One-cycle page-fault pulse |
| fault_vpn | output | 20 | Page number that faulted |
| fault_level | output | 1 | 0 = top entry absent, 1 = leaf entry invalid |

## Verification
With no memory stalls, the result of a full walk is due on the fourth clock edge after the accept edge, and a top-level fault on the second. The bench counts those edges and samples on the falling edge that follows, so each pulse is checked in the one cycle it exists, and `busy` is checked on the edge after it. The bench's memory model logs every address that completes a handshake, which lets read counts and addresses be compared with values computed from the table contents the bench wrote. Stalled runs check the result and a latency longer than four edges, not an exact cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TOP_REQ,
      ST_TOP_WAIT,
      ST_LEAF_REQ,
      ST_LEAF_WAIT,
      ST_DONE,
      ST_FAULT
   } walk_state_e;

   localparam int FLAG_W      = 4;
   localparam int BIT_PRESENT = 0;
   localparam int ENTRY_SHIFT = 2;   // entries are 4 bytes

   localparam logic LVL_TOP  = 1'b0;
   localparam logic LVL_LEAF = 1'b1;

endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
   parameter int PTE_W   = 32,
   parameter int FRAME_W = 20
) (
   input  logic [PTE_W-1:0]           entry,
   output logic                       present,
   output logic [FRAME_W-1:0]         frame,
   output logic [ptw_pkg::FLAG_W-1:0] flags
);
   localparam int FRAME_LSB = PTE_W - FRAME_W;

   if (FRAME_LSB < ptw_pkg::FLAG_W) begin : g_bad_layout
      $error("frame field overlaps the flag bits");
   end

   assign present = entry[ptw_pkg::BIT_PRESENT];
   assign frame   = entry[PTE_W-1 -: FRAME_W];
   assign flags   = entry[ptw_pkg::FLAG_W-1:0];
endmodule

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc #(
   parameter int PA_W         = 32,
   parameter int TOP_IDX_W    = 10,
   parameter int LEAF_IDX_W   = 10,
   parameter int OFF_W        = 12,
   parameter bit BASE_ALIGNED = 1'b0
) (
   input  logic [PA_W-1:0]                   base,
   input  logic [TOP_IDX_W+LEAF_IDX_W-1:0]   vpn,
   input  logic [PA_W-OFF_W-1:0]             leaf_table_frame,
   input  logic                              leaf_level,
   output logic [PA_W-1:0]                   addr
);
   localparam int FRAME_W = PA_W - OFF_W;
   localparam int SH      = ptw_pkg::ENTRY_SHIFT;

   if (LEAF_IDX_W + SH > OFF_W) begin : g_bad_leaf
      $error("second-level table does not fit in one page");
   end
   if (TOP_IDX_W + SH > PA_W) begin : g_bad_top
      $error("top-level table wider than address space");
   end

   logic [TOP_IDX_W-1:0]  top_idx;
   logic [LEAF_IDX_W-1:0] leaf_idx;
   logic [PA_W-1:0]       top_off;
   logic [PA_W-1:0]       top_addr;
   logic [PA_W-1:0]       leaf_addr;

   assign top_idx  = vpn[TOP_IDX_W+LEAF_IDX_W-1 -: TOP_IDX_W];
   assign leaf_idx = vpn[LEAF_IDX_W-1:0];
   assign top_off  = PA_W'(top_idx) << SH;

   if (BASE_ALIGNED) begin : g_or_base
      assign top_addr = base | top_off;
   end else begin : g_add_base
      assign top_addr = base + top_off;
   end

   // the leaf offset never crosses the page, so concatenation is exact
   assign leaf_addr = (PA_W'(leaf_table_frame) << OFF_W) | (PA_W'(leaf_idx) << SH);

   assign addr = leaf_level ? leaf_addr : top_addr;

   logic unused_ok;
   assign unused_ok = ^{FRAME_W};
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic miss_valid,
   input  logic mem_req_ready,
   input  logic mem_rsp_valid,
   input  logic rsp_present,
   output logic accept,
   output logic top_load,
   output logic leaf_load,
   output logic leaf_level,
   output logic mem_req_valid,
   output logic busy,
   output logic refill_valid,
   output logic fault_valid,
   output logic fault_level
);
   import ptw_pkg::*;

   walk_state_e state_q;
   logic        level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         level_q <= LVL_TOP;
      end else begin
         unique case (state_q)
            ST_IDLE:      if (miss_valid) state_q <= ST_TOP_REQ;
            ST_TOP_REQ:   if (mem_req_ready) state_q <= ST_TOP_WAIT;
            ST_TOP_WAIT:
               if (mem_rsp_valid) begin
                  if (rsp_present) begin
                     state_q <= ST_LEAF_REQ;
                  end else begin
                     state_q <= ST_FAULT;
                     level_q <= LVL_TOP;
                  end
               end
            ST_LEAF_REQ:  if (mem_req_ready) state_q <= ST_LEAF_WAIT;
            ST_LEAF_WAIT:
               if (mem_rsp_valid) begin
                  if (rsp_present) begin
                     state_q <= ST_DONE;
                  end else begin
                     state_q <= ST_FAULT;
                     level_q <= LVL_LEAF;
                  end
               end
            ST_DONE:      state_q <= ST_IDLE;
            ST_FAULT:     state_q <= ST_IDLE;
            default:      state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy          = (state_q != ST_IDLE);
      accept        = (state_q == ST_IDLE) && miss_valid;
      top_load      = (state_q == ST_TOP_WAIT) && mem_rsp_valid && rsp_present;
      leaf_load     = (state_q == ST_LEAF_WAIT) && mem_rsp_valid;
      mem_req_valid = (state_q == ST_TOP_REQ) || (state_q == ST_LEAF_REQ);
      leaf_level    = (state_q == ST_LEAF_REQ);
      refill_valid  = (state_q == ST_DONE);
      fault_valid   = (state_q == ST_FAULT);
      fault_level   = level_q;
   end

   // R12: one outcome per walk
   a_r12_single_result: assert property (@(posedge clk) disable iff (!rst_n)
      !(refill_valid && fault_valid));

   // R2: a walk only starts after a presented miss
   a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(miss_valid));

   // R2: the walker is free the cycle after a result
   a_r2_free_after: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_valid || fault_valid) |=> !busy);

   // R10: a stalled request stays asserted
   a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

   // R12: results are single-cycle pulses
   a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_valid || fault_valid) |=> !(refill_valid || fault_valid));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
   parameter int VA_W         = 32,
   parameter int PA_W         = 32,
   parameter int PTE_W        = 32,
   parameter int TOP_IDX_W    = 10,
   parameter int LEAF_IDX_W   = 10,
   parameter int OFF_W        = 12,
   parameter bit BASE_ALIGNED = 1'b0
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [PA_W-1:0]                    pt_base,
   input  logic                               miss_valid,
   input  logic [TOP_IDX_W+LEAF_IDX_W-1:0]    miss_vpn,
   output logic                               busy,
   output logic                               mem_req_valid,
   input  logic                               mem_req_ready,
   output logic [PA_W-1:0]                    mem_req_addr,
   input  logic                               mem_rsp_valid,
   input  logic [PTE_W-1:0]                   mem_rsp_data,
   output logic                               refill_valid,
   output logic [TOP_IDX_W+LEAF_IDX_W-1:0]    refill_vpn,
   output logic [PA_W-OFF_W-1:0]              refill_frame,
   output logic [ptw_pkg::FLAG_W-1:0]         refill_flags,
   output logic                               fault_valid,
   output logic [TOP_IDX_W+LEAF_IDX_W-1:0]    fault_vpn,
   output logic                               fault_level
);
   localparam int VPN_W   = TOP_IDX_W + LEAF_IDX_W;
   localparam int FRAME_W = PA_W - OFF_W;
   localparam int FL_W    = ptw_pkg::FLAG_W;

   if (VPN_W + OFF_W != VA_W) begin : g_bad_split
      $error("index and offset widths do not cover the virtual address");
   end
   if (FRAME_W > PTE_W - FL_W) begin : g_bad_frame
      $error("frame number does not fit in a table entry");
   end

   logic                 accept, top_load, leaf_load, leaf_level;
   logic                 rsp_present;
   logic [FRAME_W-1:0]   rsp_frame;
   logic [FL_W-1:0]      rsp_flags;

   logic [VPN_W-1:0]     vpn_q;
   logic [FRAME_W-1:0]   table_frame_q;
   logic [FRAME_W-1:0]   leaf_frame_q;
   logic [FL_W-1:0]      leaf_flags_q;

   ptw_pte_decode #(.PTE_W(PTE_W), .FRAME_W(FRAME_W)) u_decode (
      .entry   (mem_rsp_data),
      .present (rsp_present),
      .frame   (rsp_frame),
      .flags   (rsp_flags)
   );

   ptw_addr_calc #(
      .PA_W(PA_W), .TOP_IDX_W(TOP_IDX_W), .LEAF_IDX_W(LEAF_IDX_W),
      .OFF_W(OFF_W), .BASE_ALIGNED(BASE_ALIGNED)
   ) u_addr (
      .base             (pt_base),
      .vpn              (vpn_q),
      .leaf_table_frame (table_frame_q),
      .leaf_level       (leaf_level),
      .addr             (mem_req_addr)
   );

   ptw_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .miss_valid    (miss_valid),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .rsp_present   (rsp_present),
      .accept        (accept),
      .top_load      (top_load),
      .leaf_load     (leaf_load),
      .leaf_level    (leaf_level),
      .mem_req_valid (mem_req_valid),
      .busy          (busy),
      .refill_valid  (refill_valid),
      .fault_valid   (fault_valid),
      .fault_level   (fault_level)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpn_q         <= '0;
         table_frame_q <= '0;
         leaf_frame_q  <= '0;
         leaf_flags_q  <= '0;
      end else begin
         if (accept)    vpn_q         <= miss_vpn;
         if (top_load)  table_frame_q <= rsp_frame;
         if (leaf_load) begin
            leaf_frame_q <= rsp_frame;
            leaf_flags_q <= rsp_flags;
         end
      end
   end

   assign refill_vpn   = vpn_q;
   assign fault_vpn    = vpn_q;
   assign refill_frame = leaf_frame_q;
   assign refill_flags = leaf_flags_q;

   // R10: address does not move while the memory stalls
   a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

   // R3: the captured page number holds through a walk
   a_r3_vpn_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !refill_valid && !fault_valid) |=> $stable(vpn_q));

   // R9: a refill always carries a valid leaf
   a_r9_refill_valid_leaf: assert property (@(posedge clk) disable iff (!rst_n)
      refill_valid |-> refill_flags[ptw_pkg::BIT_PRESENT]);

   // R1: idle outputs after reset
   a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(mem_req_valid || refill_valid || fault_valid));
endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
   localparam logic [31:0] BASE = 32'h0001_0000;

   typedef struct packed {
      logic [19:0] vpn;
      logic [1:0]  kind;   // 0 refill, 1 top fault, 2 leaf fault
      logic [19:0] frame;
      logic [3:0]  flags;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{20'h00403, 2'd0, 20'hABCDE, 4'hF},
      '{20'h007FF, 2'd0, 20'h12345, 4'h3},
      '{20'hFFC00, 2'd0, 20'h0FFFF, 4'h1},
      '{20'h00807, 2'd1, 20'h00000, 4'h0},
      '{20'h00404, 2'd2, 20'h00000, 4'h0},
      '{20'h01401, 2'd1, 20'h00000, 4'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_valid = 1'b0;
   logic [19:0] miss_vpn = '0;
   logic        busy, mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        refill_valid, fault_valid, fault_level;
   logic [19:0] refill_vpn, fault_vpn, refill_frame;
   logic [3:0]  refill_flags;

   int checks = 0;
   int failures = 0;

   logic [31:0] pmem [int unsigned];
   logic [31:0] rd_log [64];
   int          rd_cnt = 0;
   int          stall = 0;
   logic        pend = 1'b0;
   logic [31:0] pend_addr = '0;

   always #10 clk = ~clk;

   ptw_walker u0 (
      .clk(clk), .rst_n(rst_n), .pt_base(BASE),
      .miss_valid(miss_valid), .miss_vpn(miss_vpn), .busy(busy),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .refill_valid(refill_valid),
      .refill_vpn(refill_vpn), .refill_frame(refill_frame),
      .refill_flags(refill_flags), .fault_valid(fault_valid),
      .fault_vpn(fault_vpn), .fault_level(fault_level)
   );

   function automatic logic [31:0] rd(input logic [31:0] a);
      return pmem.exists(a) ? pmem[a] : 32'h0;
   endfunction

   // memory model: one-cycle response after handshake, optional stalls
   always @(negedge clk) begin
      logic nr;
      mem_rsp_valid = pend;
      mem_rsp_data  = pend ? rd(pend_addr) : 32'h0;
      nr = (stall == 0);
      if (stall > 0) stall = stall - 1;
      mem_req_ready = nr;
      pend = mem_req_valid && nr && rst_n;
      if (pend) begin
         pend_addr = mem_req_addr;
         rd_log[rd_cnt % 64] = mem_req_addr;
         rd_cnt = rd_cnt + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic walk(input logic [19:0] vpn, input bit hold_miss,
                       output int lat, output bit got_refill, output bit got_fault,
                       output int nreads, output int first_rd, output bit busy_after);
      int c0;
      @(negedge clk);
      miss_valid = 1'b1;
      miss_vpn   = vpn;
      c0 = rd_cnt;
      first_rd = c0;
      @(posedge clk);
      @(negedge clk);
      if (hold_miss) miss_vpn = ~vpn;
      else miss_valid = 1'b0;
      lat = 0;
      got_refill = 1'b0;
      got_fault = 1'b0;
      while (lat < 60 && !got_refill && !got_fault) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         got_refill = refill_valid;
         got_fault  = fault_valid;
      end
      miss_valid = 1'b0;
      nreads = rd_cnt - c0;
      @(posedge clk);
      @(negedge clk);
      busy_after = busy;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int lat, nrd, first;
      bit gr, gf, ba;
      logic [31:0] top_a, leaf_a, top_e;

      // page tables
      pmem[BASE + 4*1]     = 32'h0002_0001;
      pmem[32'h0002_0000 + 4*3]     = 32'hABCD_E00F;
      pmem[32'h0002_0000 + 4*10'h3FF] = 32'h1234_5003;
      pmem[BASE + 4*10'h3FF] = 32'h0003_0001;
      pmem[32'h0003_0000]  = 32'h0FFF_F001;
      pmem[BASE + 4*5]     = 32'h0004_000E;  // flags set but absent

      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 busy in reset", {31'd0, busy}, 32'd0);
      check("R1 req in reset", {31'd0, mem_req_valid}, 32'd0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R1 results after reset", {30'd0, refill_valid, fault_valid}, 32'd0);
      check("R1 busy after reset", {31'd0, busy}, 32'd0);

      for (int i = 0; i < 6; i++) begin
         walk(VEC[i].vpn, 1'b0, lat, gr, gf, nrd, first, ba);
         top_a = BASE + 32'(VEC[i].vpn[19:10]) * 4;
         check("R4 top address", rd_log[first % 64], top_a);
         check("R2 busy drops after result", {31'd0, ba}, 32'd0);
         if (VEC[i].kind == 2'd0) begin
            top_e  = rd(top_a);
            leaf_a = 32'(top_e[31:12]) * 4096 + 32'(VEC[i].vpn[9:0]) * 4;
            check("R6 leaf address", rd_log[(first + 1) % 64], leaf_a);
            check("R9 refill pulse", {30'd0, gr, gf}, 32'd2);
            check("R9 refill vpn", 32'(refill_vpn), 32'(VEC[i].vpn));
            check("R5 refill frame", 32'(refill_frame), 32'(VEC[i].frame));
            check("R5 refill flags", 32'(refill_flags), 32'(VEC[i].flags));
            check("R11 refill latency", lat, 4);
            check("R12 read count", nrd, 2);
         end else if (VEC[i].kind == 2'd1) begin
            check("R7 top fault pulse", {30'd0, gr, gf}, 32'd1);
            check("R7 fault level", {31'd0, fault_level}, 32'd0);
            check("R7 single read", nrd, 1);
            check("R11 top fault latency", lat, 2);
            check("R7 fault vpn", 32'(fault_vpn), 32'(VEC[i].vpn));
         end else begin
            check("R8 leaf fault pulse", {30'd0, gr, gf}, 32'd1);
            check("R8 fault level", {31'd0, fault_level}, 32'd1);
            check("R8 two reads", nrd, 2);
            check("R8 fault vpn", 32'(fault_vpn), 32'(VEC[i].vpn));
         end
      end

      // R10 memory stalls
      #3 stall = 3;
      walk(20'h00403, 1'b0, lat, gr, gf, nrd, first, ba);
      check("R10 stalled refill", {30'd0, gr, gf}, 32'd2);
      check("R10 stalled frame", 32'(refill_frame), 32'hABCDE);
      check("R10 stall lengthens walk", {31'd0, lat > 4}, 32'd1);
      check("R10 stalled reads", nrd, 2);

      // R3 miss held high while busy
      walk(20'h007FF, 1'b1, lat, gr, gf, nrd, first, ba);
      check("R3 vpn kept", 32'(refill_vpn), 32'h007FF);
      check("R3 no extra read", nrd, 2);
      check("R3 idle after", {31'd0, ba}, 32'd0);
      check("R3 frame kept", 32'(refill_frame), 32'h12345);

      // R1 reset in the middle of a walk
      @(negedge clk);
      miss_valid = 1'b1;
      miss_vpn = 20'h00403;
      @(negedge clk);
      miss_valid = 1'b0;
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R1 reset aborts walk", {30'd0, busy, mem_req_valid}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 quiet after reset", {30'd0, refill_valid, fault_valid}, 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule